// File: doc/BRIEF.md
# PWM Trip Override Stage

This block sits between a PWM generator and its two output pins, A and B. When a protective event occurs, it replaces the generator's waveform with a programmed action. Every pin runs a fixed-priority chain with three levels. The top level is driven by a combined, latched trip. The second and third levels are driven by two compare events that belong to that pin. There are two separate sets of action codes, one for counting up and one for counting down, and the count-direction input picks which set is used.

The combined trip is the OR of two latches, a one-shot latch and a per-cycle latch. The one-shot latch is set by the enabled one-shot inputs and by any compare event routed to it. It stays set until software clears it. The per-cycle latch is set in the same way by its own sources. It is released by the zero-count strobe when auto-release is enabled, and it can also be cleared by software.

A latched trip applies its top-level action to both pins. A compare event that is not routed into either latch acts only on its own pin, and only while it is asserted. A small write-only register port sets the actions, the source enables, the release mode and the clears. Both the pin values and the high-impedance enables are registered, so the pins change only on clock edges.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset, all outputs are 0, all action codes are 0, no trip source is enabled, and per-cycle auto-release is on. With these settings a trip input pulse has no effect on the outputs.
- R2: When no source is active on a pin, that pin's output equals its raw input from the previous clock, and its high-impedance enable is 0.
- R3: Every pin arbitrates its sources in the order combined trip (highest), event 1, event 2 (lowest). When `cnt_up` is 1, the arbitration uses the action set at address 0. When `cnt_up` is 0, it uses the set at address 1. In each set, pin A uses bits [5:0] and pin B uses bits [11:6]. Within a pin, the trip action is in bits [1:0], event 1 in [3:2] and event 2 in [5:4].
- R4: Action codes work as follows. Code 0 is neutral and defers to the next active source. Code 1 forces the pin high. Code 2 forces it low. Code 3 is "do nothing": the pin follows its raw input, and all lower levels are blocked.
- R5: The high-impedance enable is 1 when at least one source is active on the pin and every active source has code 0. The pin output then still follows the raw input.
- R6: Address 2 selects the trip sources. Bits [3:0] enable the one-shot inputs. Bits [7:4] enable the per-cycle inputs. Bits [11:8] route events A1, A2, B1, B2 to the one-shot latch, and bits [15:12] route them to the per-cycle latch. A latched trip applies each pin's trip action to both pins, two clocks after the source is sampled.
- R7: An event routed to neither latch acts only on its own pin, one clock after it is sampled, and only while it is asserted. A routed event has no direct action.
- R8: The one-shot latch is not released by the zero-count strobe. It clears only when bit 0 is written to address 4.
- R9: The per-cycle latch is released at the zero-count strobe when bit 0 of address 3 is 1, and it is held when that bit is 0. Writing bit 1 to address 4 clears it.
- R10: If a latch is set and cleared in the same clock, the set wins.
- R11: An action write sampled at one clock edge shapes the outputs from the next edge on. Outputs change only at clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_a_in | input | 1 | Raw PWM A from the generator |
| pwm_b_in | input | 1 | Raw PWM B from the generator |
| cnt_up | input | 1 | 1 when the counter counts up, 0 when it counts down |
| zero_stb | input | 1 | One-clock strobe when the counter reaches zero |
| osht_trip_in | input | N_OSHT | One-shot trip sources |
| cbc_trip_in | input | N_CBC | Per-cycle trip sources |
| dc_a1 | input | 1 | Compare event 1 for pin A |
| dc_a2 | input | 1 | Compare event 2 for pin A |
| dc_b1 | input | 1 | Compare event 1 for pin B |
| dc_b2 | input | 1 | Compare event 2 for pin B |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| pwm_a_out | output | 1 | Overridden pin A value |
| pwm_b_out | output | 1 | Overridden pin B value |
| hiz_a_out | output | 1 | High-impedance enable for pin A |
| hiz_b_out | output | 1 | High-impedance enable for pin B |

## Verification
Two situations are hard to reach from the ports: a higher level that is active but neutral, and a routed event that must not also act directly. To reach the first, the stimulus sets the trip level through a one-shot pulse and holds the events at the same time. It sweeps every code triple, every mix of active sources and both raw levels. It also loads the opposite direction's set with inverted codes, so that a wrong direction choice shows up. For the second, an event is routed into the per-cycle latch while the trip code is neutral and the event's own code is force-low. The only result that satisfies the requirements is a high-impedance pin that follows its raw value.

// File: rtl/trip_guard_pkg.sv
package trip_guard_pkg;

    localparam int ACT_W    = 2;
    localparam int N_LVL    = 3;
    localparam int N_PIN    = 2;
    localparam int N_EVT    = 4;
    localparam int PIN_ACT_W = ACT_W * N_LVL;
    localparam int DIR_ACT_W = PIN_ACT_W * N_PIN;

    typedef enum logic [ACT_W-1:0] {
        ACT_PASS = 2'd0,
        ACT_HIGH = 2'd1,
        ACT_LOW  = 2'd2,
        ACT_HOLD = 2'd3
    } act_e;

    // register addresses
    localparam int REG_ACT_UP = 0;
    localparam int REG_ACT_DN = 1;
    localparam int REG_SEL    = 2;
    localparam int REG_MODE   = 3;
    localparam int REG_CLR    = 4;

    // field positions in the source select register
    localparam int SEL_OSHT_LSB = 0;
    localparam int SEL_CBC_LSB  = 4;
    localparam int SEL_EVO_LSB  = 8;
    localparam int SEL_EVC_LSB  = 12;
    localparam int SEL_FIELD_W  = 4;

    localparam int CLR_OSHT_BIT = 0;
    localparam int CLR_CBC_BIT  = 1;
    localparam int MODE_ZCLR_BIT = 0;

endpackage

// File: rtl/trip_latches.sv
module trip_latches
    import trip_guard_pkg::*;
#(
    parameter int N_OSHT = 2,
    parameter int N_CBC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_OSHT-1:0] osht_in,
    input  logic [N_CBC-1:0]  cbc_in,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic [N_OSHT-1:0] osht_en,
    input  logic [N_CBC-1:0]  cbc_en,
    input  logic [N_EVT-1:0]  evt_osht_sel,
    input  logic [N_EVT-1:0]  evt_cbc_sel,
    input  logic              zero_stb,
    input  logic              zclr_en,
    input  logic              osht_swclr,
    input  logic              cbc_swclr,
    output logic              osht_set_o,
    output logic              cbc_set_o,
    output logic              osht_q_o,
    output logic              cbc_q_o
);

    typedef struct packed {
        logic osht;
        logic cbc;
    } latch_t;

    latch_t lt_d, lt_q;

    always_comb begin
        osht_set_o = (|(osht_in & osht_en)) | (|(evt_in & evt_osht_sel));
        cbc_set_o  = (|(cbc_in & cbc_en)) | (|(evt_in & evt_cbc_sel));
        lt_d       = lt_q;
        // a new set always dominates a clear arriving in the same cycle
        lt_d.osht  = osht_set_o | (lt_q.osht & ~osht_swclr);
        lt_d.cbc   = cbc_set_o  | (lt_q.cbc & ~cbc_swclr & ~(zclr_en & zero_stb));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lt_q <= '0;
        else        lt_q <= lt_d;
    end

    assign osht_q_o = lt_q.osht;
    assign cbc_q_o  = lt_q.cbc;

endmodule

// File: rtl/trip_pin_arbiter.sv
module trip_pin_arbiter
    import trip_guard_pkg::*;
#(
    parameter int LEVELS = N_LVL
) (
    input  logic [LEVELS*ACT_W-1:0] act_i,
    input  logic [LEVELS-1:0]       active_i,
    input  logic                    raw_i,
    output logic                    data_o,
    output logic                    hiz_o
);

    logic decided;
    act_e win;

    // level 0 is the highest priority; the first active non-neutral code wins
    always_comb begin
        decided = 1'b0;
        win     = ACT_PASS;
        for (int i = 0; i < LEVELS; i++) begin
            if (!decided && active_i[i] &&
                act_e'(act_i[i*ACT_W +: ACT_W]) != ACT_PASS) begin
                decided = 1'b1;
                win     = act_e'(act_i[i*ACT_W +: ACT_W]);
            end
        end
        case (win)
            ACT_HIGH: data_o = 1'b1;
            ACT_LOW:  data_o = 1'b0;
            default:  data_o = raw_i;
        endcase
        hiz_o = !decided && (|active_i);
    end

endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import trip_guard_pkg::*;
#(
    parameter int N_OSHT = 2,
    parameter int N_CBC  = 2,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_a_in,
    input  logic              pwm_b_in,
    input  logic              cnt_up,
    input  logic              zero_stb,
    input  logic [N_OSHT-1:0] osht_trip_in,
    input  logic [N_CBC-1:0]  cbc_trip_in,
    input  logic              dc_a1,
    input  logic              dc_a2,
    input  logic              dc_b1,
    input  logic              dc_b2,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              pwm_a_out,
    output logic              pwm_b_out,
    output logic              hiz_a_out,
    output logic              hiz_b_out
);

    typedef struct packed {
        logic [DIR_ACT_W-1:0] act_up;
        logic [DIR_ACT_W-1:0] act_dn;
        logic [N_OSHT-1:0]    osht_en;
        logic [N_CBC-1:0]     cbc_en;
        logic [N_EVT-1:0]     evt_osht;
        logic [N_EVT-1:0]     evt_cbc;
        logic                 zclr_en;
        logic [N_PIN-1:0]     pin_data;
        logic [N_PIN-1:0]     pin_hiz;
    } state_t;

    state_t st_d, st_q;

    logic [N_EVT-1:0]     evt_vec;
    logic [N_EVT-1:0]     evt_direct;
    logic [DIR_ACT_W-1:0] act_sel;
    logic [N_PIN-1:0]     raw_vec;
    logic [N_PIN-1:0]     arb_data;
    logic [N_PIN-1:0]     arb_hiz;
    logic                 osht_swclr, cbc_swclr;
    logic                 osht_set_w, cbc_set_w;
    logic                 osht_q_w, cbc_q_w;
    logic                 trip_any;
    logic                 zclr_en_w;
    logic [ACT_W-1:0]     act_a_trip;
    logic                 wr_clr;

    assign evt_vec    = {dc_b2, dc_b1, dc_a2, dc_a1};
    assign raw_vec    = {pwm_b_in, pwm_a_in};
    assign evt_direct = evt_vec & ~(st_q.evt_osht | st_q.evt_cbc);
    assign act_sel    = cnt_up ? st_q.act_up : st_q.act_dn;
    assign act_a_trip = act_sel[ACT_W-1:0];
    assign trip_any   = osht_q_w | cbc_q_w;
    assign zclr_en_w  = st_q.zclr_en;

    assign wr_clr     = cfg_we && (cfg_addr == ADDR_W'(REG_CLR));
    assign osht_swclr = wr_clr && cfg_wdata[CLR_OSHT_BIT];
    assign cbc_swclr  = wr_clr && cfg_wdata[CLR_CBC_BIT];

    trip_latches #(
        .N_OSHT(N_OSHT),
        .N_CBC (N_CBC)
    ) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .osht_in     (osht_trip_in),
        .cbc_in      (cbc_trip_in),
        .evt_in      (evt_vec),
        .osht_en     (st_q.osht_en),
        .cbc_en      (st_q.cbc_en),
        .evt_osht_sel(st_q.evt_osht),
        .evt_cbc_sel (st_q.evt_cbc),
        .zero_stb    (zero_stb),
        .zclr_en     (st_q.zclr_en),
        .osht_swclr  (osht_swclr),
        .cbc_swclr   (cbc_swclr),
        .osht_set_o  (osht_set_w),
        .cbc_set_o   (cbc_set_w),
        .osht_q_o    (osht_q_w),
        .cbc_q_o     (cbc_q_w)
    );

    // one arbiter per pin; pin p owns events 2p and 2p+1
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        trip_pin_arbiter #(
            .LEVELS(N_LVL)
        ) u_arb (
            .act_i   (act_sel[p*PIN_ACT_W +: PIN_ACT_W]),
            .active_i({evt_direct[2*p+1], evt_direct[2*p], trip_any}),
            .raw_i   (raw_vec[p]),
            .data_o  (arb_data[p]),
            .hiz_o   (arb_hiz[p])
        );
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_addr == ADDR_W'(REG_ACT_UP)) begin
                st_d.act_up = cfg_wdata[DIR_ACT_W-1:0];
            end
            if (cfg_addr == ADDR_W'(REG_ACT_DN)) begin
                st_d.act_dn = cfg_wdata[DIR_ACT_W-1:0];
            end
            if (cfg_addr == ADDR_W'(REG_SEL)) begin
                st_d.osht_en  = cfg_wdata[SEL_OSHT_LSB +: N_OSHT];
                st_d.cbc_en   = cfg_wdata[SEL_CBC_LSB +: N_CBC];
                st_d.evt_osht = cfg_wdata[SEL_EVO_LSB +: N_EVT];
                st_d.evt_cbc  = cfg_wdata[SEL_EVC_LSB +: N_EVT];
            end
            if (cfg_addr == ADDR_W'(REG_MODE)) begin
                st_d.zclr_en = cfg_wdata[MODE_ZCLR_BIT];
            end
        end
        st_d.pin_data = arb_data;
        st_d.pin_hiz  = arb_hiz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.zclr_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_a_out = st_q.pin_data[0];
    assign pwm_b_out = st_q.pin_data[1];
    assign hiz_a_out = st_q.pin_hiz[0];
    assign hiz_b_out = st_q.pin_hiz[1];

endmodule

// File: rtl/trip_guard_chk.sv
module trip_guard_chk
    import trip_guard_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_a_in,
    input logic             pwm_a_out,
    input logic             hiz_a_out,
    input logic             zero_stb,
    input logic             osht_q,
    input logic             cbc_q,
    input logic             osht_set,
    input logic             cbc_set,
    input logic             osht_swclr,
    input logic             zclr_en,
    input logic             trip_any,
    input logic [N_EVT-1:0] evt_direct,
    input logic [ACT_W-1:0] act_a_trip
);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_osht_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        osht_q && !osht_swclr |=> osht_q);

    assert_cbc_zero_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cbc_q && zero_stb && zclr_en && !cbc_set |=> !cbc_q);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        osht_set |=> osht_q);

    assert_hiz_follows_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && hiz_a_out |-> pwm_a_out == $past(pwm_a_in));

    assert_idle_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(trip_any) && !$past(evt_direct[0]) && !$past(evt_direct[1])
        |-> !hiz_a_out && pwm_a_out == $past(pwm_a_in));

    assert_trip_force_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(trip_any) && $past(act_a_trip) == ACT_LOW |-> !pwm_a_out);

endmodule

bind pwm_trip_guard trip_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_a_in  (pwm_a_in),
    .pwm_a_out (pwm_a_out),
    .hiz_a_out (hiz_a_out),
    .zero_stb  (zero_stb),
    .osht_q    (osht_q_w),
    .cbc_q     (cbc_q_w),
    .osht_set  (osht_set_w),
    .cbc_set   (cbc_set_w),
    .osht_swclr(osht_swclr),
    .zclr_en   (zclr_en_w),
    .trip_any  (trip_any),
    .evt_direct(evt_direct),
    .act_a_trip(act_a_trip)
);

// File: tb/pwm_trip_guard_tb.sv
`timescale 1ns/1ps
module pwm_trip_guard_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_a_in = 1'b0, pwm_b_in = 1'b0, cnt_up = 1'b1, zero_stb = 1'b0;
    logic [1:0] osht_trip_in = '0, cbc_trip_in = '0;
    logic dc_a1 = 1'b0, dc_a2 = 1'b0, dc_b1 = 1'b0, dc_b2 = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic pwm_a_out, pwm_b_out, hiz_a_out, hiz_b_out;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_trip_guard u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .cnt_up(cnt_up), .zero_stb(zero_stb), .osht_trip_in(osht_trip_in),
        .cbc_trip_in(cbc_trip_in), .dc_a1(dc_a1), .dc_a2(dc_a2), .dc_b1(dc_b1),
        .dc_b2(dc_b2), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out),
        .hiz_a_out(hiz_a_out), .hiz_b_out(hiz_b_out)
    );

    // {dir, codes{ev2,ev1,trip}, active{ev2,ev1,trip}, raw, exp_data, exp_hiz}
    localparam logic [12:0] VECS [0:8] = '{
        {1'b0, 6'b001011, 3'b011, 1'b1, 1'b1, 1'b0},
        {1'b0, 6'b000110, 3'b011, 1'b1, 1'b0, 1'b0},
        {1'b0, 6'b001000, 3'b011, 1'b1, 1'b0, 1'b0},
        {1'b0, 6'b010000, 3'b111, 1'b0, 1'b1, 1'b0},
        {1'b0, 6'b100100, 3'b110, 1'b0, 1'b1, 1'b0},
        {1'b0, 6'b000000, 3'b101, 1'b1, 1'b1, 1'b1},
        {1'b0, 6'b111111, 3'b000, 1'b0, 1'b0, 1'b0},
        {1'b0, 6'b100000, 3'b100, 1'b1, 1'b0, 1'b0},
        {1'b1, 6'b000001, 3'b001, 1'b0, 1'b1, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // expected pin result from the action rules: returns {data, hiz}
    function automatic logic [1:0] model(input logic [5:0] c, input logic [2:0] a, input logic raw);
        for (int i = 0; i < 3; i++) begin
            if (a[i] && c[2*i +: 2] != 2'd0) begin
                if (c[2*i +: 2] == 2'd1) return 2'b10;
                if (c[2*i +: 2] == 2'd2) return 2'b00;
                return {raw, 1'b0};
            end
        end
        return {raw, |a};
    endfunction

    task automatic run_vec(input logic dir, input logic [5:0] c, input logic [2:0] a,
                           input logic raw, input logic ed, input logic eh, input string req);
        wr(dir ? 3'd1 : 3'd0, 16'({c, c}));
        wr(dir ? 3'd0 : 3'd1, 16'({~c, ~c}));
        wr(3'd4, 16'h0001);
        cnt_up = !dir;
        pwm_a_in = raw; pwm_b_in = raw;
        dc_a1 = a[1]; dc_a2 = a[2]; dc_b1 = a[1]; dc_b2 = a[2];
        osht_trip_in = {1'b0, a[0]};
        @(posedge clk); @(negedge clk);
        osht_trip_in = '0;
        tick(1);
        chk(req, "pin A data", pwm_a_out, ed);
        chk(req, "pin A hiz",  hiz_a_out, eh);
        chk(req, "pin B data", pwm_b_out, ed);
        chk(req, "pin B hiz",  hiz_b_out, eh);
        dc_a1 = 0; dc_a2 = 0; dc_b1 = 0; dc_b2 = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] m;
        pwm_a_in = 1'b1; pwm_b_in = 1'b1;
        tick(3);
        chk("R1", "reset A", pwm_a_out, 1'b0);
        chk("R1", "reset B", pwm_b_out, 1'b0);
        chk("R1", "reset hiz A", hiz_a_out, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R2", "pass A", pwm_a_out, 1'b1);
        chk("R2", "pass hiz B", hiz_b_out, 1'b0);
        pwm_a_in = 1'b0; pwm_b_in = 1'b1;
        osht_trip_in = 2'b11; cbc_trip_in = 2'b11;
        tick(1);
        osht_trip_in = '0; cbc_trip_in = '0;
        tick(2);
        chk("R1", "sources disabled A", pwm_a_out, 1'b0);
        chk("R1", "sources disabled B", pwm_b_out, 1'b1);
        chk("R1", "sources disabled hiz", hiz_a_out, 1'b0);

        // priority table, then full sweep in both directions
        wr(3'd2, 16'h0001);
        for (int v = 0; v < 9; v++) begin
            run_vec(VECS[v][12], VECS[v][11:6], VECS[v][5:3], VECS[v][2],
                    VECS[v][1], VECS[v][0], "R3/R4/R5 table");
        end
        for (int d = 0; d < 2; d++) begin
            for (int c = 0; c < 64; c++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int r = 0; r < 2; r++) begin
                        m = model(6'(c), 3'(a), 1'(r));
                        run_vec(1'(d), 6'(c), 3'(a), 1'(r), m[1], m[0], "R3/R4/R5 sweep");
                    end
                end
            end
        end

        // R6 and R9: per-cycle trip hits both pins, released at zero
        wr(3'd4, 16'h0003);
        cnt_up = 1'b1;
        wr(3'd0, 16'({6'b000001, 6'b000010}));
        wr(3'd2, 16'h0010);
        pwm_a_in = 1'b1; pwm_b_in = 1'b0;
        cbc_trip_in = 2'b01; tick(1); cbc_trip_in = '0; tick(1);
        chk("R6", "trip A low", pwm_a_out, 1'b0);
        chk("R6", "trip B high", pwm_b_out, 1'b1);
        zero_stb = 1'b1; tick(1); zero_stb = 1'b0; tick(1);
        chk("R9", "zero release A", pwm_a_out, 1'b1);
        chk("R9", "zero release B", pwm_b_out, 1'b0);
        wr(3'd3, 16'h0000);
        cbc_trip_in = 2'b01; tick(1); cbc_trip_in = '0;
        zero_stb = 1'b1; tick(1); zero_stb = 1'b0; tick(2);
        chk("R9", "held without auto release", pwm_a_out, 1'b0);
        wr(3'd4, 16'h0002); tick(1);
        chk("R9", "software clear", pwm_a_out, 1'b1);
        wr(3'd3, 16'h0001);

        // R8: one-shot survives zero strobe
        wr(3'd2, 16'h0001);
        osht_trip_in = 2'b01; tick(1); osht_trip_in = '0;
        zero_stb = 1'b1; tick(1); zero_stb = 1'b0; tick(2);
        chk("R8", "one-shot held", pwm_a_out, 1'b0);
        wr(3'd4, 16'h0001); tick(1);
        chk("R8", "one-shot cleared", pwm_a_out, 1'b1);

        // R10: set and clear together
        osht_trip_in = 2'b01;
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 16'h0001;
        tick(1);
        osht_trip_in = '0; cfg_we = 1'b0;
        tick(1);
        chk("R10", "set beats clear", pwm_a_out, 1'b0);
        wr(3'd4, 16'h0001);

        // R6 routed event hits both pins; R7 routed event has no direct action
        wr(3'd0, 16'({6'b000000, 6'b001000}));
        wr(3'd2, 16'h1000);
        dc_a1 = 1'b1; tick(2);
        chk("R7", "routed no direct A", pwm_a_out, 1'b1);
        chk("R6", "routed trip hiz A", hiz_a_out, 1'b1);
        chk("R6", "routed trip hiz B", hiz_b_out, 1'b1);
        dc_a1 = 1'b0; wr(3'd4, 16'h0002);

        // R7: direct event on own pin only, only while asserted
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'({6'b000100, 6'b001000}));
        tick(1);
        dc_a1 = 1'b1; tick(1);
        chk("R7", "direct A low", pwm_a_out, 1'b0);
        chk("R7", "B untouched", pwm_b_out, 1'b0);
        chk("R7", "B no hiz", hiz_b_out, 1'b0);
        dc_a1 = 1'b0; tick(1);
        chk("R7", "released A", pwm_a_out, 1'b1);

        // R11: action write timing
        wr(3'd0, 16'h0000);
        dc_a1 = 1'b1; tick(1);
        chk("R5", "neutral active hiz", hiz_a_out, 1'b1);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 16'h0008;
        tick(1);
        cfg_we = 1'b0;
        chk("R11", "not yet applied", pwm_a_out, 1'b1);
        tick(1);
        chk("R11", "applied next edge", pwm_a_out, 1'b0);
        dc_a1 = 1'b0;
        tick(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule